// File: doc/BRIEF.md
# Calendar Clock Register File

This block is the software-facing register file of a calendar clock and its alarm. It is an APB slave. It holds the tick divider, the date and time words that are loaded into the counter, the control word, the alarm match words and a single-source interrupt register group. It drives each setting straight out to the counter and alarm logic, which are separate blocks. It also returns the live time, the live status and the pending interrupt state on reads.

A calendar value spans two words, and the counter can advance between two reads. To make the pair coherent, a read of the time-of-day word also copies the live date into a shadow register. Later reads of the date readback word return that shadow. Software therefore reads the time word first and the date word second. Writing a 1 to the load bit of the control word sends a one-cycle load strobe to the counter, and that bit always reads back as zero. Every access completes without wait states.

Top module: `calclk_regs`

## Requirements
- R1: After reset, every writable register holds zero. This means `divOut`, `dateSetOut`, `timeSetOut`, `alarmDateOut`, `alarmTimeOut`, `runEnable`, `noLeapForce`, `loadPulse` and `irqOut` are all 0.
- R2: A write to offset 0x00 keeps only bits 15:0 as the divider. Reads return it with bits 31:16 as zero, and `divOut` follows it.
- R3: The setup words keep only their defined bits. Offset 0x04 keeps mask 0x00FFFF1F and offset 0x08 keeps 0x071F3F3F. Offset 0x10 stores the bits in 0x17FFFF1F and offset 0x14 stores 0x071F3F3F plus 0xF0000000. The masked word is read back and driven on the matching output port.
- R4: In the control word at 0x0C, bit 0 is the run enable (`runEnable`) and bit 8 forces the non-leap year (`noLeapForce`). Both are read/write. Bit 1 reads the `running` input and ignores writes.
- R5: A write to 0x0C with bit 4 set raises `loadPulse` for exactly the one cycle after the write completes. A write with bit 4 clear raises no pulse, and bit 4 always reads 0.
- R6: A read of 0x1C returns `liveTime` masked by 0x071F3F3F. On the clock edge that completes that read, the block copies `liveDate` masked by 0x00FFFF1F into a shadow register. Reads of 0x18 return the shadow, whatever `liveDate` does afterwards.
- R7: Bit 29 of the alarm date word at 0x10 reads the `alarmActive` input and ignores writes.
- R8: Bit 0 of 0x20 reads the `alarmHit` input and ignores writes. Bit 0 of 0x24 (enable) and bit 0 of 0x28 (force) are read/write. Bit 0 of 0x2C and `irqOut` both equal (raw AND enable) OR force.
- R9: `pready` is always 1 and `pslverr` always 0. Offsets 0x30 to 0x3C read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 6 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| pready | output | 1 | Always 1 (zero wait) |
| pslverr | output | 1 | Always 0 |
| running | input | 1 | Counter reports it is running |
| liveDate | input | 32 | Live date word from the counter |
| liveTime | input | 32 | Live time-of-day word from the counter |
| alarmActive | input | 1 | Alarm logic reports matching is armed |
| alarmHit | input | 1 | Raw alarm interrupt level |
| divOut | output | 16 | Tick divider setting |
| dateSetOut | output | 32 | Date word to load into the counter |
| timeSetOut | output | 32 | Time word to load into the counter |
| alarmDateOut | output | 32 | Alarm date match word with its enables |
| alarmTimeOut | output | 32 | Alarm time match word with its enables |
| runEnable | output | 1 | Counter enable |
| noLeapForce | output | 1 | Force the current year to be non-leap |
| loadPulse | output | 1 | One-cycle load strobe to the counter |
| irqOut | output | 1 | Masked and forced interrupt |

## Verification
Two events can fall on the same clock edge: the edge that completes a time-word read, which captures the date shadow, and a change of the live date from the counter. The bench changes `liveDate` in the same cycle the read enters its access phase, and changes it again right after the completing edge. It then reads the date word and expects the value that was present during the access phase, neither the earlier nor the later one. The bench also raises force and enable together with the raw alarm level, and checks that the interrupt output stays the OR of the two paths while each path is removed in turn.

// File: rtl/calclk_pkg.sv
package calclk_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int NUM_SETUP = 4;

  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t IDX_DIV   = idx_t'(0);
  localparam idx_t IDX_DSET  = idx_t'(1);
  localparam idx_t IDX_TSET  = idx_t'(2);
  localparam idx_t IDX_CTRL  = idx_t'(3);
  localparam idx_t IDX_ADATE = idx_t'(4);
  localparam idx_t IDX_ATIME = idx_t'(5);
  localparam idx_t IDX_DNOW  = idx_t'(6);
  localparam idx_t IDX_TNOW  = idx_t'(7);
  localparam idx_t IDX_RAW   = idx_t'(8);
  localparam idx_t IDX_INTE  = idx_t'(9);
  localparam idx_t IDX_INTF  = idx_t'(10);
  localparam idx_t IDX_MSTAT = idx_t'(11);

  localparam logic [DATA_W-1:0] MASK_DATE   = 32'h00FF_FF1F;
  localparam logic [DATA_W-1:0] MASK_TIME   = 32'h071F_3F3F;
  localparam logic [DATA_W-1:0] MASK_ADATE  = 32'h17FF_FF1F;
  localparam logic [DATA_W-1:0] MASK_ATIME  = 32'hF71F_3F3F;
  localparam int                ADATE_ACT_BIT = 29;

  // strobes from bus control to datapath
  typedef struct packed {
    logic wr;
    logic rd;
    idx_t idx;
    logic snap;
    logic load;
  } apbStb_t;

  function automatic idx_t setupIdx(input int g);
    case (g)
      0: setupIdx = IDX_DSET;
      1: setupIdx = IDX_TSET;
      2: setupIdx = IDX_ADATE;
      default: setupIdx = IDX_ATIME;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] setupMask(input int g);
    case (g)
      0: setupMask = MASK_DATE;
      1: setupMask = MASK_TIME;
      2: setupMask = MASK_ADATE;
      default: setupMask = MASK_ATIME;
    endcase
  endfunction
endpackage

// File: rtl/calclk_maskreg.sv
module calclk_maskreg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/calclk_ctrl.sv
module calclk_ctrl
  import calclk_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              loadBit,
  output apbStb_t           stb
);
  logic accPhase;
  logic unusedLow;

  assign accPhase  = psel && penable;
  assign unusedLow = ^paddr[1:0];

  always_comb begin
    stb.wr   = accPhase && pwrite;
    stb.rd   = accPhase && !pwrite;
    stb.idx  = paddr[ADDR_W-1:2];
    stb.snap = stb.rd && (stb.idx == IDX_TNOW);
    stb.load = stb.wr && (stb.idx == IDX_CTRL) && loadBit;
  end
endmodule

// File: rtl/calclk_dp.sv
module calclk_dp
  import calclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  apbStb_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running,
  input  logic [DATA_W-1:0] liveDate,
  input  logic [DATA_W-1:0] liveTime,
  input  logic              alarmActive,
  input  logic              alarmHit,
  output logic [DATA_W-1:0] rdMux,
  output logic [DIV_W-1:0]  divOut,
  output logic [DATA_W-1:0] setupWords [NUM_SETUP],
  output logic              runEnable,
  output logic              noLeapForce,
  output logic              loadPulse,
  output logic              irqOut
);
  logic [DIV_W-1:0]  divReg;
  logic              ctrlEn;
  logic              noLeapReg;
  logic              inteReg;
  logic              intfReg;
  logic [DATA_W-1:0] dateShadow;
  logic              maskedStat;

  // the four masked setup words share one register shape
  for (genvar g = 0; g < NUM_SETUP; g++) begin : g_setup
    localparam idx_t              WIDX  = setupIdx(g);
    localparam logic [DATA_W-1:0] WMASK = setupMask(g);
    calclk_maskreg #(.W(DATA_W), .MASK(WMASK)) u_word (
      .clk  (clk),
      .rstN (rstN),
      .we   (stb.wr && (stb.idx == WIDX)),
      .wdata(wdata),
      .q    (setupWords[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg     <= '0;
      ctrlEn     <= 1'b0;
      noLeapReg  <= 1'b0;
      inteReg    <= 1'b0;
      intfReg    <= 1'b0;
      loadPulse  <= 1'b0;
      dateShadow <= '0;
    end else begin
      loadPulse <= stb.load;
      if (stb.wr) begin
        case (stb.idx)
          IDX_DIV:  divReg <= wdata[DIV_W-1:0];
          IDX_CTRL: begin
            ctrlEn    <= wdata[0];
            noLeapReg <= wdata[8];
          end
          IDX_INTE: inteReg <= wdata[0];
          IDX_INTF: intfReg <= wdata[0];
          default: ;
        endcase
      end
      if (stb.snap) dateShadow <= liveDate & MASK_DATE;
    end
  end

  assign maskedStat  = (alarmHit && inteReg) || intfReg;
  assign divOut      = divReg;
  assign runEnable   = ctrlEn;
  assign noLeapForce = noLeapReg;
  assign irqOut      = maskedStat;

  always_comb begin
    rdMux = '0;
    case (stb.idx)
      IDX_DIV:   rdMux = DATA_W'(divReg);
      IDX_DSET:  rdMux = setupWords[0];
      IDX_TSET:  rdMux = setupWords[1];
      IDX_CTRL:  begin
        rdMux[0] = ctrlEn;
        rdMux[1] = running;
        rdMux[8] = noLeapReg;
      end
      IDX_ADATE: begin
        rdMux = setupWords[2];
        rdMux[ADATE_ACT_BIT] = alarmActive;
      end
      IDX_ATIME: rdMux = setupWords[3];
      IDX_DNOW:  rdMux = dateShadow;
      IDX_TNOW:  rdMux = liveTime & MASK_TIME;
      IDX_RAW:   rdMux[0] = alarmHit;
      IDX_INTE:  rdMux[0] = inteReg;
      IDX_INTF:  rdMux[0] = intfReg;
      IDX_MSTAT: rdMux[0] = maskedStat;
      default:   rdMux = '0;
    endcase
  end
endmodule

// File: rtl/calclk_regs.sv
module calclk_regs
  import calclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              running,
  input  logic [DATA_W-1:0] liveDate,
  input  logic [DATA_W-1:0] liveTime,
  input  logic              alarmActive,
  input  logic              alarmHit,
  output logic [DIV_W-1:0]  divOut,
  output logic [DATA_W-1:0] dateSetOut,
  output logic [DATA_W-1:0] timeSetOut,
  output logic [DATA_W-1:0] alarmDateOut,
  output logic [DATA_W-1:0] alarmTimeOut,
  output logic              runEnable,
  output logic              noLeapForce,
  output logic              loadPulse,
  output logic              irqOut
);
  apbStb_t           stb;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] setupWords [NUM_SETUP];

  calclk_ctrl u_ctrl (
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .loadBit(pwdata[4]),
    .stb    (stb)
  );

  calclk_dp #(.DIV_W(DIV_W)) u_dp (
    .clk        (pclk),
    .rstN       (presetn),
    .stb        (stb),
    .wdata      (pwdata),
    .running    (running),
    .liveDate   (liveDate),
    .liveTime   (liveTime),
    .alarmActive(alarmActive),
    .alarmHit   (alarmHit),
    .rdMux      (rdMux),
    .divOut     (divOut),
    .setupWords (setupWords),
    .runEnable  (runEnable),
    .noLeapForce(noLeapForce),
    .loadPulse  (loadPulse),
    .irqOut     (irqOut)
  );

  assign dateSetOut   = setupWords[0];
  assign timeSetOut   = setupWords[1];
  assign alarmDateOut = setupWords[2];
  assign alarmTimeOut = setupWords[3];
  assign prdata       = (psel && !pwrite) ? rdMux : '0;
  assign pready       = 1'b1;
  assign pslverr      = 1'b0;
endmodule

// File: rtl/calclk_regs_chk.sv
module calclk_regs_chk (
  input logic        pclk,
  input logic        presetn,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [5:0]  paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        pslverr,
  input logic        running,
  input logic [31:0] liveDate,
  input logic        loadPulse,
  input logic        irqOut,
  input logic        forceBit,
  input logic [31:0] dateShadow
);
  logic timeRd;
  logic ctrlLoadWr;
  assign timeRd     = psel && penable && !pwrite && (paddr == 6'h1C);
  assign ctrlLoadWr = psel && penable && pwrite && (paddr == 6'h0C) && pwdata[4];

  p_reset_quiet_r1: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(presetn) |-> (!loadPulse && !irqOut));

  p_running_bit_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && paddr == 6'h0C) |-> (prdata[1] == running));

  p_load_single_r5: assert property (@(posedge pclk) disable iff (!presetn)
    loadPulse |=> !loadPulse);

  p_load_cause_r5: assert property (@(posedge pclk) disable iff (!presetn)
    loadPulse |-> $past(ctrlLoadWr));

  p_snap_take_r6: assert property (@(posedge pclk) disable iff (!presetn)
    timeRd |=> (dateShadow == ($past(liveDate) & 32'h00FF_FF1F)));

  p_snap_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
    !timeRd |=> $stable(dateShadow));

  p_force_irq_r8: assert property (@(posedge pclk) disable iff (!presetn)
    forceBit |-> irqOut);

  p_zero_wait_r9: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);
endmodule

bind calclk_regs calclk_regs_chk u_chk (
  .pclk      (pclk),
  .presetn   (presetn),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .pready    (pready),
  .pslverr   (pslverr),
  .running   (running),
  .liveDate  (liveDate),
  .loadPulse (loadPulse),
  .irqOut    (irqOut),
  .forceBit  (u_dp.intfReg),
  .dateShadow(u_dp.dateShadow)
);

// File: tb/calclk_regs_test.sv
module calclk_regs_test;
  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        running = 1'b0;
  logic [31:0] liveDate = '0, liveTime = '0;
  logic        alarmActive = 1'b0, alarmHit = 1'b0;
  logic [15:0] divOut;
  logic [31:0] dateSetOut, timeSetOut, alarmDateOut, alarmTimeOut;
  logic        runEnable, noLeapForce, loadPulse, irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  calclk_regs uut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .running(running),
    .liveDate(liveDate), .liveTime(liveTime), .alarmActive(alarmActive),
    .alarmHit(alarmHit), .divOut(divOut), .dateSetOut(dateSetOut),
    .timeSetOut(timeSetOut), .alarmDateOut(alarmDateOut),
    .alarmTimeOut(alarmTimeOut), .runEnable(runEnable),
    .noLeapForce(noLeapForce), .loadPulse(loadPulse), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: compares each read access phase against the scoreboard
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected read got=%h exp=none", prdata);
      end else begin
        chk(tagQ.pop_front(), prdata, expQ.pop_front());
      end
      chk("R9 ready/err", {30'b0, pready, pslverr}, 32'h2);
    end
  end

  task automatic apbWrite(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [5:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); #1 psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 presetn = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 divOut", 32'(divOut), 0);
    chk("R1 setup outs", dateSetOut | timeSetOut | alarmDateOut | alarmTimeOut, 0);
    chk("R1 flags", {28'b0, runEnable, noLeapForce, loadPulse, irqOut}, 0);
    apbRead(6'h0C, 32'h0, "R1 ctrl read");

    // R2 divider
    apbWrite(6'h00, 32'hDEAD_BEEF);
    chk("R2 divOut", 32'(divOut), 32'hBEEF);
    apbRead(6'h00, 32'h0000_BEEF, "R2 div read");

    // R3 setup masks
    apbWrite(6'h04, 32'hFFFF_FFFF);
    apbWrite(6'h08, 32'hFFFF_FFFF);
    apbWrite(6'h10, 32'hFFFF_FFFF);
    apbWrite(6'h14, 32'hFFFF_FFFF);
    chk("R3 dateSetOut", dateSetOut, 32'h00FF_FF1F);
    chk("R3 timeSetOut", timeSetOut, 32'h071F_3F3F);
    chk("R3 alarmDateOut", alarmDateOut, 32'h17FF_FF1F);
    chk("R3 alarmTimeOut", alarmTimeOut, 32'hF71F_3F3F);
    apbRead(6'h04, 32'h00FF_FF1F, "R3 date read");
    apbRead(6'h08, 32'h071F_3F3F, "R3 time read");
    apbRead(6'h10, 32'h17FF_FF1F, "R3 alarm date read");
    apbRead(6'h14, 32'hF71F_3F3F, "R3 alarm time read");
    apbWrite(6'h04, 32'h0012_3405);
    apbRead(6'h04, 32'h0012_3405, "R3 date pattern");

    // R7 alarm active bit
    alarmActive = 1;
    apbRead(6'h10, 32'h37FF_FF1F, "R7 active reads 1");
    apbWrite(6'h10, 32'h0000_0000);
    apbRead(6'h10, 32'h2000_0000, "R7 write ignored");
    alarmActive = 0;
    apbWrite(6'h10, 32'h2000_0000);
    apbRead(6'h10, 32'h0000_0000, "R7 bit29 not stored");

    // R4 control
    apbWrite(6'h0C, 32'h0000_0103);
    chk("R4 runEnable", 32'(runEnable), 1);
    chk("R4 noLeapForce", 32'(noLeapForce), 1);
    apbRead(6'h0C, 32'h0000_0101, "R4 running low");
    running = 1;
    apbRead(6'h0C, 32'h0000_0103, "R4 running high");
    running = 0;

    // R5 load strobe
    apbWrite(6'h0C, 32'h0000_0011);
    chk("R5 pulse high", 32'(loadPulse), 1);
    chk("R5 enable kept", 32'(runEnable), 1);
    chk("R5 noLeap cleared", 32'(noLeapForce), 0);
    @(posedge clk); #1;
    chk("R5 pulse one cycle", 32'(loadPulse), 0);
    apbRead(6'h0C, 32'h0000_0001, "R5 load reads 0");
    apbWrite(6'h0C, 32'h0000_0001);
    chk("R5 no pulse", 32'(loadPulse), 0);

    // R6 coherent snapshot
    liveDate = 32'hFF0A_BC11;
    liveTime = 32'hFFFF_FFFF;
    apbRead(6'h1C, 32'h071F_3F3F, "R6 time read");
    liveDate = 32'h0055_6607;
    apbRead(6'h18, 32'h000A_BC11, "R6 shadow held");
    // coincidence: date changes while the time read is in its access phase
    liveTime = 32'h0102_0304;
    liveDate = 32'h0011_1111;
    expQ.push_back(32'h0102_0304); tagQ.push_back("R6 time read 2");
    @(posedge clk); #1 psel = 1; pwrite = 0; paddr = 6'h1C; penable = 0;
    @(posedge clk); #1 penable = 1; liveDate = 32'hE022_2202;
    @(posedge clk); #1 psel = 0; penable = 0; liveDate = 32'h0033_3303;
    apbRead(6'h18, 32'h0022_2202, "R6 edge capture");
    apbRead(6'h18, 32'h0022_2202, "R6 second date read");

    // R8 interrupts
    alarmHit = 1; #1;
    chk("R8 irq masked", 32'(irqOut), 0);
    apbRead(6'h20, 32'h1, "R8 raw");
    apbRead(6'h2C, 32'h0, "R8 masked off");
    apbWrite(6'h24, 32'h1);
    chk("R8 irq enabled", 32'(irqOut), 1);
    apbRead(6'h2C, 32'h1, "R8 masked on");
    alarmHit = 0; #1;
    chk("R8 irq drops", 32'(irqOut), 0);
    apbWrite(6'h28, 32'h1);
    chk("R8 irq forced", 32'(irqOut), 1);
    apbWrite(6'h24, 32'h0);
    chk("R8 force alone", 32'(irqOut), 1);
    apbRead(6'h28, 32'h1, "R8 force read");
    apbWrite(6'h20, 32'hFFFF_FFFF);
    apbRead(6'h20, 32'h0, "R8 raw write ignored");
    apbWrite(6'h28, 32'h0);
    chk("R8 irq clear", 32'(irqOut), 0);

    // R9 unmapped
    apbWrite(6'h30, 32'hFFFF_FFFF);
    apbWrite(6'h3C, 32'hFFFF_FFFF);
    apbRead(6'h30, 32'h0, "R9 unmapped read");
    apbRead(6'h00, 32'h0000_BEEF, "R9 div untouched");
    apbRead(6'h24, 32'h0, "R9 enable untouched");
    chk("R9 outputs untouched", dateSetOut, 32'h0012_3405);

    repeat (3) @(posedge clk);
    chk("R9 scoreboard drained", 32'(expQ.size()), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule